// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Side Flag Recovery Latency

This block buffers fixed-width words between a producer clocked by `wr_clk` and a consumer clocked by `rd_clk`, with no phase or frequency relation assumed between the two. Words sit in a dual-port array indexed by binary pointers. Each pointer carries one extra wrap bit, so a full array can be told apart from an empty one. Each side publishes its pointer as a Gray code. The opposite side brings that code in through a chain of `SYNC_STAGES` flops, turns it back into binary, and then registers a status decision from it.

The write side drives `full` and `almost_full` from a three-state machine. **WS_ROOM** means fewer than `DEPTH-AF_GAP+1` words are stored. **WS_NEAR** means the count is at or above that threshold but below `DEPTH`. **WS_FULL** means `DEPTH` words are stored. The next state is picked every write clock from the projected occupancy, so every transition between the three states can occur, including jumps over WS_NEAR. Because the read pointer needs two flops to arrive and the state register adds one more, space freed by a read shows up on the write flags three write clocks after the read edge. If the two clock edges almost coincide, the first synchronizer flop may miss the new value, and the flags then recover one write clock later.

The read side has a two-state output machine. **RS_DRAINED** means the output register holds no word. **RS_HOLD** means it does. In standard mode (`FWFT=0`), a read enable applied while words remain loads the output register, and `rd_valid` pulses in the following read cycle. In that mode the machine always returns from RS_HOLD to RS_DRAINED unless a new word is taken. In first-word-fall-through mode (`FWFT=1`), the machine fetches the head word by itself (RS_DRAINED to RS_HOLD). It keeps the word in RS_HOLD until `rd_en` consumes it, and then either refills (stays in RS_HOLD) or falls back to RS_DRAINED.

Top module: `dcfifo_top`

## Requirements
- R1: Words leave on `rd_data` in exactly the order they were accepted on the write side, across pointer wrap-around, with none lost or duplicated.
- R2: In standard mode `full` is high immediately after the write edge that stores the `DEPTH`-th word. In first-word-fall-through mode the output register also holds one word, so `full` rises only after `DEPTH+1` words have been accepted. `full` only ever rises on a cycle with `wr_en` high.
- R3: A write presented while `full` is high is dropped: the write pointer does not move and the word never appears on the read side.
- R4: After a read edge that removes a word from a full array, `full` is still high after the second following write-clock edge and low after the third (or the fourth when the two clock edges nearly coincide).
- R5: `almost_full` is high whenever the stored count is at least `DEPTH-AF_GAP+1`, and is always high while `full` is high. When reads drain a full array, it clears with the same three-write-clock latency after the read that brings the count down to `DEPTH-AF_GAP`, which with `AF_GAP=4` is the fourth read.
- R6: In standard mode, `rd_valid` is high in the read cycle right after an edge where `rd_en` was high and `empty` low, and low otherwise. `rd_data` carries the word taken at that edge.
- R7: In first-word-fall-through mode, the head word appears on `rd_data` with `rd_valid` high without any `rd_en`. It stays stable until `rd_en` consumes it.
- R8: A read enable while `empty` is high has no effect: no word is produced, and no stored word is skipped.
- R9: The flag recovery latency of R4 and R5 is the same in both modes. It counts from the read edge that takes a word out of the array, including the automatic head fetch.
- R10: While reset is asserted and just after it is released, `full` and `almost_full` are low, `empty` is high and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Store `wr_data` on this write edge if not full |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No space left; writes are dropped |
| almost_full | output | 1 | Stored count at or above `DEPTH-AF_GAP+1` |
| rd_en | input | 1 | Take a word (standard) or consume the shown word (fall-through) |
| rd_data | output | DATA_W | Output word register |
| rd_valid | output | 1 | `rd_data` holds a delivered word |
| empty | output | 1 | No word can be read now |

## Verification
The bench builds two copies side by side, both with `DATA_W=8`, `ADDR_W=4` (16 entries), `AF_GAP=4` and `SYNC_STAGES=2`. One copy has `FWFT=0` and the other `FWFT=1`, so the same write traffic reveals how the two output styles differ in capacity and in when the data appears. The small depth lets the bench fill the array, overflow it, drain it and wrap the pointers several times in a few hundred cycles. The write clock runs at 10 ns and the read clock at 12 ns, with edges offset so that they never coincide. The nominal three-write-clock recovery of `full` and `almost_full` is therefore exact, and the bench can check it to the cycle in both modes.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    // Write-side status machine: occupancy band of the array.
    typedef enum logic [1:0] {
        WS_ROOM = 2'd0,
        WS_NEAR = 2'd1,
        WS_FULL = 2'd2
    } wr_state_e;

    // Read-side output machine: is a word parked in the output register.
    typedef enum logic {
        RS_DRAINED = 1'b0,
        RS_HOLD    = 1'b1
    } rd_state_e;

endpackage

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Unregistered read port; the read side owns the output register.
    assign rdata = store[raddr];

endmodule

// File: rtl/dcfifo_ptr_xfer.sv
module dcfifo_ptr_xfer #(
    parameter int PW     = 5,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] chain [STAGES];
    logic [PW-1:0] gray_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain[s] <= '0;
            end
        end else begin
            chain[0] <= gray_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign gray_sync = chain[STAGES-1];

    // Gray to binary: each bit is the parity of all bits at or above it.
    always_comb begin
        for (int b = 0; b < PW; b++) begin
            bin_out[b] = ^(gray_sync >> b);
        end
    end

endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
    import dcfifo_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AF_GAP = 4,
    parameter int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rd_bin_sync,
    output logic [PW-1:0] wr_bin,
    output logic [PW-1:0] wr_gray,
    output logic          mem_we,
    output logic          full,
    output logic          almost_full
);
    localparam int            DEPTH    = 1 << AW;
    localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);
    localparam logic [PW-1:0] NEAR_OCC = PW'(DEPTH - AF_GAP + 1);

    wr_state_e     state_q;
    wr_state_e     state_d;
    logic          accept;
    logic [PW-1:0] bin_d;
    logic [PW-1:0] occ_d;

    // Next-state decision from the projected occupancy.
    always_comb begin
        accept = wr_en && (state_q != WS_FULL);
        bin_d  = wr_bin + PW'(accept);
        occ_d  = bin_d - rd_bin_sync;
        if (occ_d == FULL_OCC) begin
            state_d = WS_FULL;
        end else if (occ_d >= NEAR_OCC) begin
            state_d = WS_NEAR;
        end else begin
            state_d = WS_ROOM;
        end
    end

    // State and pointer registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_ROOM;
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            state_q <= state_d;
            wr_bin  <= bin_d;
            wr_gray <= bin_d ^ (bin_d >> 1);
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_we = accept;
        unique case (state_q)
            WS_ROOM: begin full = 1'b0; almost_full = 1'b0; end
            WS_NEAR: begin full = 1'b0; almost_full = 1'b1; end
            WS_FULL: begin full = 1'b1; almost_full = 1'b1; end
            default: begin full = 1'b0; almost_full = 1'b0; end
        endcase
    end

endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
    import dcfifo_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DW   = 8,
    parameter int FWFT = 0,
    parameter int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] wr_bin_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_bin,
    output logic [PW-1:0] rd_gray,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          empty
);
    rd_state_e     state_q;
    rd_state_e     state_d;
    logic          avail_q;
    logic          avail_d;
    logic          pop;
    logic [PW-1:0] bin_d;

    // Mode picks when a word leaves the array.
    generate
        if (FWFT != 0) begin : g_fwft
            always_comb pop = avail_q && ((state_q == RS_DRAINED) || rd_en);
        end else begin : g_std
            always_comb pop = avail_q && rd_en;
        end
    endgenerate

    always_comb begin
        bin_d   = rd_bin + PW'(pop);
        avail_d = (wr_bin_sync != bin_d);
        unique case (state_q)
            RS_DRAINED: state_d = pop ? RS_HOLD : RS_DRAINED;
            RS_HOLD: begin
                if (pop) begin
                    state_d = RS_HOLD;
                end else if ((FWFT == 0) || rd_en) begin
                    state_d = RS_DRAINED;
                end else begin
                    state_d = RS_HOLD;
                end
            end
            default: state_d = RS_DRAINED;
        endcase
    end

    // State, pointer and output-word registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_DRAINED;
            rd_bin  <= '0;
            rd_gray <= '0;
            avail_q <= 1'b0;
            rd_data <= '0;
        end else begin
            state_q <= state_d;
            rd_bin  <= bin_d;
            rd_gray <= bin_d ^ (bin_d >> 1);
            avail_q <= avail_d;
            if (pop) begin
                rd_data <= mem_rdata;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rd_addr = rd_bin[AW-1:0];
        unique case (state_q)
            RS_DRAINED: begin
                rd_valid = 1'b0;
                empty    = (FWFT != 0) ? 1'b1 : !avail_q;
            end
            RS_HOLD: begin
                rd_valid = 1'b1;
                empty    = (FWFT != 0) ? 1'b0 : !avail_q;
            end
            default: begin
                rd_valid = 1'b0;
                empty    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int AF_GAP      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FWFT        = 0
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_bin;
    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     rd_bin;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     rd_bin_at_wr;
    logic [PW-1:0]     wr_bin_at_rd;
    logic              mem_we;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] mem_rdata;

    dcfifo_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (wr_bin[ADDR_W-1:0]),
        .wdata  (wr_data),
        .raddr  (rd_addr),
        .rdata  (mem_rdata)
    );

    dcfifo_ptr_xfer #(.PW(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .gray_in (rd_gray),
        .bin_out (rd_bin_at_wr)
    );

    dcfifo_ptr_xfer #(.PW(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wr_gray),
        .bin_out (wr_bin_at_rd)
    );

    dcfifo_wr_side #(.AW(ADDR_W), .AF_GAP(AF_GAP), .PW(PW)) u_wr (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_bin_sync (rd_bin_at_wr),
        .wr_bin      (wr_bin),
        .wr_gray     (wr_gray),
        .mem_we      (mem_we),
        .full        (full),
        .almost_full (almost_full)
    );

    dcfifo_rd_side #(.AW(ADDR_W), .DW(DATA_W), .FWFT(FWFT), .PW(PW)) u_rd (
        .clk         (rd_clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .wr_bin_sync (wr_bin_at_rd),
        .mem_rdata   (mem_rdata),
        .rd_addr     (rd_addr),
        .rd_bin      (rd_bin),
        .rd_gray     (rd_gray),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .empty       (empty)
    );

endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
    parameter int FWFT = 0,
    parameter int DW   = 8,
    parameter int PW   = 5
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          full,
    input logic          almost_full,
    input logic          rd_en,
    input logic          rd_valid,
    input logic [DW-1:0] rd_data,
    input logic          empty,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] rd_bin
);
    // R3: a write against a full array leaves the write pointer alone.
    assert_drop_when_full_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wr_bin));

    // R2: full only rises on a cycle that carried a write.
    assert_full_rises_on_write_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(full) |-> $past(wr_en));

    // R5: full implies almost_full.
    assert_full_has_afull_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);

    // R10: flags idle while reset is held.
    always @(posedge wr_clk) begin
        if (!rst_n) begin
            assert_reset_flags_R10: assert (!full && !almost_full);
        end
    end

    generate
        if (FWFT == 0) begin : g_std_props
            // R6: valid follows a granted read by one read clock.
            assert_valid_after_read_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
                rd_valid |-> $past(rd_en && !empty));
            // R8: a read against an empty array moves nothing.
            assert_empty_read_ignored_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
                (rd_en && empty) |=> ($stable(rd_bin) && !rd_valid));
        end else begin : g_fwft_props
            // R7: a shown word stays until consumed.
            assert_head_held_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
                (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));
        end
    endgenerate

endmodule

bind dcfifo_top dcfifo_chk #(.FWFT(FWFT), .DW(DATA_W), .PW(ADDR_W + 1)) chk_i (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .full        (full),
    .almost_full (almost_full),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .empty       (empty),
    .wr_bin      (wr_bin),
    .rd_bin      (rd_bin)
);

// File: tb/dcfifo_top_tb_top.sv
`timescale 1ns/100ps
module dcfifo_top_tb_top;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int GAP   = 4;
    localparam int DEPTH = 1 << AW;

    logic wclk, rclk, rst_n;
    logic wr_en;
    logic [DW-1:0] wr_data;
    logic rd_en_s, rd_en_f;
    logic full_s, af_s, val_s, emp_s;
    logic full_f, af_f, val_f, emp_f;
    logic [DW-1:0] dat_s, dat_f;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [DW-1:0] q_s[$];
    logic [DW-1:0] q_f[$];
    bit pend_s = 0;

    dcfifo_top #(.DATA_W(DW), .ADDR_W(AW), .AF_GAP(GAP), .SYNC_STAGES(2), .FWFT(0)) dut_i (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full_s), .almost_full(af_s), .rd_en(rd_en_s), .rd_data(dat_s),
        .rd_valid(val_s), .empty(emp_s));

    dcfifo_top #(.DATA_W(DW), .ADDR_W(AW), .AF_GAP(GAP), .SYNC_STAGES(2), .FWFT(1)) dut_fw_i (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full_f), .almost_full(af_f), .rd_en(rd_en_f), .rd_data(dat_f),
        .rd_valid(val_f), .empty(emp_f));

    // 100 MHz write clock; 12 ns read clock whose edges never meet it.
    initial begin wclk = 0; forever #5 wclk = ~wclk; end
    initial begin rclk = 0; forever #6 rclk = ~rclk; end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Write-side model: record what each copy accepts.
    always @(negedge wclk) begin
        #0.5;
        if (rst_n && wr_en) begin
            if (!full_s) q_s.push_back(wr_data);
            if (!full_f) q_f.push_back(wr_data);
        end
    end

    // Read-side model, compared every read clock.
    always @(negedge rclk) begin
        #0.5;
        if (rst_n) begin
            check(val_s == pend_s, "R6 std valid timing", val_s, pend_s);
            if (val_s) begin
                if (q_s.size() == 0) check(0, "R1 std unexpected word", dat_s, 0);
                else begin
                    logic [DW-1:0] e;
                    e = q_s.pop_front();
                    check(dat_s == e, "R1 std order", dat_s, e);
                end
            end
            pend_s = rd_en_s && !emp_s;
            if (val_f) begin
                if (q_f.size() == 0) check(0, "R1 fwft unexpected word", dat_f, 0);
                else begin
                    check(dat_f == q_f[0], "R1 R7 fwft head", dat_f, q_f[0]);
                    if (rd_en_f) void'(q_f.pop_front());
                end
            end
        end else begin
            pend_s = 0;
        end
    end

    task automatic write_word(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en = 1; wr_data = d;
        @(posedge wclk);
        #0.5;
    endtask

    task automatic plain_read();
        @(negedge rclk);
        rd_en_s = 1; rd_en_f = 1;
        @(negedge rclk);
        rd_en_s = 0; rd_en_f = 0;
    endtask

    // One read on both copies; flag (0 = full, 1 = almost_full) must
    // hold after the 2nd write edge and clear after the 3rd.
    task automatic timed_read(input bit use_af);
        @(negedge rclk);
        rd_en_s = 1; rd_en_f = 1;
        @(posedge rclk);
        fork
            begin
                @(negedge rclk);
                rd_en_s = 0; rd_en_f = 0;
            end
            begin
                repeat (2) @(posedge wclk);
                #0.5;
                if (use_af) begin
                    check(af_s == 1, "R5 std afull held", af_s, 1);
                    check(af_f == 1, "R9 fwft afull held", af_f, 1);
                end else begin
                    check(full_s == 1, "R4 std full held", full_s, 1);
                    check(full_f == 1, "R9 fwft full held", full_f, 1);
                end
                @(posedge wclk);
                #0.5;
                if (use_af) begin
                    check(af_s == 0, "R5 std afull cleared", af_s, 0);
                    check(af_f == 0, "R9 fwft afull cleared", af_f, 0);
                end else begin
                    check(full_s == 0, "R4 std full cleared", full_s, 0);
                    check(full_f == 0, "R9 fwft full cleared", full_f, 0);
                end
            end
        join
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            check(0, "R1 watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_data = '0; rd_en_s = 0; rd_en_f = 0;
        repeat (3) @(posedge wclk);
        #0.5;
        check(!full_s && !af_s && emp_s && !val_s, "R10 std in reset", {full_s, af_s, emp_s, val_s}, 4'b0010);
        check(!full_f && !af_f && emp_f && !val_f, "R10 fwft in reset", {full_f, af_f, emp_f, val_f}, 4'b0010);
        @(negedge wclk);
        rst_n = 1;
        repeat (2) @(posedge wclk);
        #0.5;
        check(!full_s && !af_s && emp_s && !val_s, "R10 std after reset", {full_s, af_s, emp_s, val_s}, 4'b0010);
        check(!full_f && !af_f && emp_f && !val_f, "R10 fwft after reset", {full_f, af_f, emp_f, val_f}, 4'b0010);

        // R8: reads on an empty FIFO
        repeat (3) plain_read();
        @(negedge rclk); #0.5;
        check(!val_s && emp_s, "R8 std empty read", {val_s, emp_s}, 2'b01);
        check(!val_f && emp_f, "R8 fwft empty read", {val_f, emp_f}, 2'b01);

        // Fill with DEPTH words; check flag bands after each write.
        for (int i = 0; i < DEPTH; i++) begin
            write_word(DW'(8'h10 + i));
            check(full_s == (i + 1 == DEPTH), "R2 std full band", full_s, (i + 1 == DEPTH));
            check(af_s == (i + 1 >= DEPTH - GAP + 1), "R5 std afull band", af_s, (i + 1 >= DEPTH - GAP + 1));
        end
        check(full_f == 0, "R2 fwft extra slot", full_f, 0);

        // R3: overflow attempts
        for (int i = 0; i < 3; i++) begin
            write_word(8'hEE);
            check(full_s == 1, "R3 std stays full", full_s, 1);
        end
        check(full_f == 1, "R2 fwft full after DEPTH+1", full_f, 1);
        @(negedge wclk);
        wr_en = 0;
        check(q_s.size() == DEPTH, "R3 std drops overflow", q_s.size(), DEPTH);
        check(q_f.size() == DEPTH + 1, "R3 fwft drops overflow", q_f.size(), DEPTH + 1);

        // R7 / R6: head shown only in fall-through mode
        repeat (4) @(negedge rclk);
        #0.5;
        check(val_f && dat_f == 8'h10, "R7 fwft head without rd_en", dat_f, 8'h10);
        check(!val_s, "R6 std no word without rd_en", val_s, 0);

        // R4, R5, R9: flag recovery
        timed_read(0);
        plain_read();
        plain_read();
        timed_read(1);

        // Drain past empty (R1, R8)
        @(negedge rclk);
        rd_en_s = 1; rd_en_f = 1;
        repeat (30) @(negedge rclk);
        rd_en_s = 0; rd_en_f = 0;
        repeat (2) @(negedge rclk);
        #0.5;
        check(q_s.size() == 0 && emp_s, "R1 std drained", q_s.size(), 0);
        check(q_f.size() == 0 && emp_f, "R1 fwft drained", q_f.size(), 0);

        // Streaming with wrap-around and stalls
        fork
            begin
                for (int i = 0; i < 60; i++) begin
                    @(negedge wclk);
                    wr_en = 1; wr_data = DW'(8'h40 + i);
                end
                @(negedge wclk);
                wr_en = 0;
            end
            begin
                for (int i = 0; i < 70; i++) begin
                    @(negedge rclk);
                    rd_en_s = (i % 3) != 0;
                    rd_en_f = (i % 4) != 1;
                end
            end
        join
        @(negedge rclk);
        rd_en_s = 1; rd_en_f = 1;
        repeat (40) @(negedge rclk);
        rd_en_s = 0; rd_en_f = 0;
        repeat (2) @(negedge rclk);
        #0.5;
        check(q_s.size() == 0 && emp_s, "R1 std stream drained", q_s.size(), 0);
        check(q_f.size() == 0 && emp_f, "R1 fwft stream drained", q_f.size(), 0);

        done = 1;
        finish_run();
    end

endmodule